// File: doc/BRIEF.md
# Pipeline Trap Controller

This block decides, in the same cycle a problem shows up, whether a five-stage in-order pipeline must abandon its current work and jump to a trap handler. It watches three sources. The first is a hardware-fault flag raised by the execute stage. The second is an undefined-opcode flag raised by decode. The third is an external interrupt request line driven by I/O devices. It also receives the program counter of the instruction in each of those two stages.

When it takes a trap, it does four things in that cycle. It pulses the flush strobes for the decode and execute pipeline registers. It steers the next-PC multiplexer to a handler address. It emits write strobes and data for an external 64-bit exception-PC register and an external 64-bit cause register. As a result, the handler's first instruction is fetched on the next cycle.

The handler address has two forms, chosen by a mode input:
- **Direct:** every trap lands on one base address, and software reads the cause register.
- **Vectored:** an interrupt lands on a slot of the table, offset from the base by four bytes per cause code.

A global interrupt-enable bit gates interrupts. Taking any trap clears it. A trap-return pulse sets it again and steers the PC back to the saved exception PC.

Top module: `trap_ctrl`

## Requirements
- R1: Whenever a trap is taken, `flush_dec_o`, `flush_ex_o`, `epc_we_o` and `cause_we_o` are all 1 in that same cycle, and `pc_sel_o` equals 1 (trap handler).
- R2: On a trap, `epc_wdata_o` carries the PC of the trapping instruction: `ex_pc_i` for an execute fault, `dec_pc_i` for an undefined opcode, and `ex_pc_i` (the oldest squashed instruction) for an interrupt.
- R3: On a trap, `cause_wdata_o` has bit 63 set to 1 for an interrupt and 0 otherwise, bits 62..6 set to zero, and bits 5..0 holding the code: 2 for an undefined opcode, 11 for an external interrupt, and 24 for an execute fault.
- R4: When several sources are active together, the execute fault wins over the undefined opcode, and both win over the interrupt request.
- R5: An interrupt request is taken only while the enable bit, visible on `irq_en_o`, is 1. The enable bit reads 1 after reset. A masked request produces no flush and no register write.
- R6: The cycle after any trap is taken, `irq_en_o` reads 0.
- R7: A trap-return pulse with no trap taken in that cycle does three things. It drives `pc_sel_o` to 2 with `pc_target_o` equal to `epc_rd_i`. It asserts neither flush nor either write strobe. It makes `irq_en_o` read 1 in the next cycle.
- R8: With `vec_mode_i` = 0, every trap drives `pc_target_o` to the handler base address (default 0x80000100).
- R9: With `vec_mode_i` = 1, an interrupt drives `pc_target_o` to base + 4 × code (base + 44 for the external interrupt), and a synchronous exception still goes to the base.
- R10: With no trap source taken and no trap-return, `pc_sel_o` is 0 and no flush or write strobe is asserted.
- R11: If a trap and a trap-return arrive in the same cycle, the trap is taken and `irq_en_o` reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ex_fault_i | input | 1 | Hardware fault in the execute stage |
| ex_pc_i | input | 64 | PC of the instruction in execute |
| dec_illegal_i | input | 1 | Undefined opcode in the decode stage |
| dec_pc_i | input | 64 | PC of the instruction in decode |
| irq_req_i | input | 1 | External interrupt request level |
| trap_ret_i | input | 1 | Trap-return pulse |
| vec_mode_i | input | 1 | 1 = vectored handler entry, 0 = direct |
| epc_rd_i | input | 64 | Current content of the exception-PC register |
| flush_dec_o | output | 1 | Flush strobe for the decode pipeline register |
| flush_ex_o | output | 1 | Flush strobe for the execute pipeline register |
| pc_sel_o | output | 2 | Next-PC select: 0 sequential, 1 handler, 2 return |
| pc_target_o | output | 64 | Handler or return address |
| epc_we_o | output | 1 | Exception-PC register write strobe |
| epc_wdata_o | output | 64 | Exception-PC register write data |
| cause_we_o | output | 1 | Cause register write strobe |
| cause_wdata_o | output | 64 | Cause register write data |
| irq_en_o | output | 1 | Global interrupt-enable bit |

## Verification
The assertions assume that every input is a known 0 or 1 from the first clock after reset. They also assume that `epc_rd_i` reflects the last value written through the exception-PC write port, one cycle after the write. The bench meets both assumptions. It drives every input one nanosecond after a rising edge, so all inputs hold a defined value at each edge. It also models the exception-PC register itself and feeds that value back into `epc_rd_i`. Directed sequences cover same-cycle collisions of the sources with each other and with trap-return. A long pseudo-random phase then biases each source so that masked requests, back-to-back traps and returns all occur.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        PCS_SEQ  = 2'd0,
        PCS_TRAP = 2'd1,
        PCS_RET  = 2'd2
    } pc_sel_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_EXEC = 2'd1,
        SRC_DEC  = 2'd2,
        SRC_IRQ  = 2'd3
    } trap_src_e;

    localparam int unsigned CODE_ILLEGAL = 2;
    localparam int unsigned CODE_EXT_IRQ = 11;

    typedef struct packed {
        logic irq_en;
    } ctl_state_t;

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
#(
    parameter int unsigned XLEN       = 64,
    parameter int unsigned CODE_W     = 6,
    parameter int unsigned FAULT_CODE = 24
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ex_fault_i,
    input  logic [XLEN-1:0]   ex_pc_i,
    input  logic              dec_illegal_i,
    input  logic [XLEN-1:0]   dec_pc_i,
    input  logic              irq_i,
    input  logic              irq_en_i,
    output logic              take_o,
    output logic              is_irq_o,
    output logic [CODE_W-1:0] code_o,
    output logic [XLEN-1:0]   fault_pc_o,
    output trap_src_e         src_o
);

    // Oldest instruction first, then synchronous before asynchronous.
    always_comb begin
        src_o      = SRC_NONE;
        code_o     = '0;
        fault_pc_o = ex_pc_i;
        if (ex_fault_i) begin
            src_o      = SRC_EXEC;
            code_o     = CODE_W'(FAULT_CODE);
            fault_pc_o = ex_pc_i;
        end else if (dec_illegal_i) begin
            src_o      = SRC_DEC;
            code_o     = CODE_W'(CODE_ILLEGAL);
            fault_pc_o = dec_pc_i;
        end else if (irq_i && irq_en_i) begin
            src_o      = SRC_IRQ;
            code_o     = CODE_W'(CODE_EXT_IRQ);
            fault_pc_o = ex_pc_i;
        end
    end

    assign take_o   = (src_o != SRC_NONE);
    assign is_irq_o = (src_o == SRC_IRQ);

    AST_EXEC_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ex_fault_i |-> (take_o && !is_irq_o && fault_pc_o == ex_pc_i)); // R4
    AST_DEC_OVER_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_illegal_i && !ex_fault_i) |-> (src_o == SRC_DEC && fault_pc_o == dec_pc_i)); // R4
    AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!irq_en_i && !ex_fault_i && !dec_illegal_i) |-> !take_o); // R5

endmodule

// File: rtl/trap_vector.sv
module trap_vector #(
    parameter int unsigned       XLEN      = 64,
    parameter int unsigned       CODE_W    = 6,
    parameter logic [XLEN-1:0]   BASE_ADDR = 64'h0000_0000_8000_0100,
    parameter bit                VEC_EN    = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              vec_mode_i,
    input  logic              is_irq_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [XLEN-1:0]   target_o
);

    localparam int unsigned OFS_W = CODE_W + 2;

    logic [OFS_W-1:0] slot_ofs;
    assign slot_ofs = {code_i, 2'b00};

    generate
        if (VEC_EN) begin : g_vectored
            always_comb begin
                if (vec_mode_i && is_irq_i) target_o = BASE_ADDR + XLEN'(slot_ofs);
                else                        target_o = BASE_ADDR;
            end
        end else begin : g_direct
            logic unused_vec;
            assign unused_vec = ^{vec_mode_i, is_irq_i, slot_ofs};
            assign target_o   = BASE_ADDR;
        end
    endgenerate

    AST_DIRECT_AT_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vec_mode_i |-> (target_o == BASE_ADDR)); // R8
    AST_SYNC_AT_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !is_irq_i |-> (target_o == BASE_ADDR)); // R9

endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
    import trap_pkg::*;
#(
    parameter int unsigned     XLEN        = 64,
    parameter int unsigned     CODE_W      = 6,
    parameter int unsigned     FAULT_CODE  = 24,
    parameter logic [XLEN-1:0] BASE_ADDR   = 64'h0000_0000_8000_0100,
    parameter bit              VEC_EN      = 1'b1,
    parameter bit              EN_AT_RESET = 1'b1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            ex_fault_i,
    input  logic [XLEN-1:0] ex_pc_i,
    input  logic            dec_illegal_i,
    input  logic [XLEN-1:0] dec_pc_i,
    input  logic            irq_req_i,
    input  logic            trap_ret_i,
    input  logic            vec_mode_i,
    input  logic [XLEN-1:0] epc_rd_i,
    output logic            flush_dec_o,
    output logic            flush_ex_o,
    output logic [1:0]      pc_sel_o,
    output logic [XLEN-1:0] pc_target_o,
    output logic            epc_we_o,
    output logic [XLEN-1:0] epc_wdata_o,
    output logic            cause_we_o,
    output logic [XLEN-1:0] cause_wdata_o,
    output logic            irq_en_o
);

    localparam int unsigned PAD_W = XLEN - 1 - CODE_W;

    ctl_state_t st_d, st_q;

    logic              take;
    logic              is_irq;
    logic [CODE_W-1:0] code;
    logic [XLEN-1:0]   fault_pc;
    logic [XLEN-1:0]   vec_target;
    trap_src_e         src;
    pc_sel_e           sel;

    trap_arbiter #(
        .XLEN       (XLEN),
        .CODE_W     (CODE_W),
        .FAULT_CODE (FAULT_CODE)
    ) u_arb (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .ex_fault_i    (ex_fault_i),
        .ex_pc_i       (ex_pc_i),
        .dec_illegal_i (dec_illegal_i),
        .dec_pc_i      (dec_pc_i),
        .irq_i         (irq_req_i),
        .irq_en_i      (st_q.irq_en),
        .take_o        (take),
        .is_irq_o      (is_irq),
        .code_o        (code),
        .fault_pc_o    (fault_pc),
        .src_o         (src)
    );

    trap_vector #(
        .XLEN      (XLEN),
        .CODE_W    (CODE_W),
        .BASE_ADDR (BASE_ADDR),
        .VEC_EN    (VEC_EN)
    ) u_vec (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .vec_mode_i (vec_mode_i),
        .is_irq_i   (is_irq),
        .code_i     (code),
        .target_o   (vec_target)
    );

    logic unused_src;
    assign unused_src = ^src;

    always_comb begin
        st_d          = st_q;
        sel           = PCS_SEQ;
        pc_target_o   = vec_target;
        flush_dec_o   = 1'b0;
        flush_ex_o    = 1'b0;
        epc_we_o      = 1'b0;
        cause_we_o    = 1'b0;
        epc_wdata_o   = fault_pc;
        cause_wdata_o = {is_irq, {PAD_W{1'b0}}, code};
        if (take) begin
            sel         = PCS_TRAP;
            flush_dec_o = 1'b1;
            flush_ex_o  = 1'b1;
            epc_we_o    = 1'b1;
            cause_we_o  = 1'b1;
            st_d.irq_en = 1'b0;
        end else if (trap_ret_i) begin
            sel         = PCS_RET;
            pc_target_o = epc_rd_i;
            st_d.irq_en = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q.irq_en <= EN_AT_RESET;
        else         st_q        <= st_d;
    end

    assign pc_sel_o = sel;
    assign irq_en_o = st_q.irq_en;

    AST_TRAP_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pc_sel_o == PCS_TRAP) |-> (flush_dec_o && flush_ex_o && epc_we_o && cause_we_o)); // R1
    AST_TRAP_DISABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        epc_we_o |=> !irq_en_o); // R6
    AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cause_we_o && cause_wdata_o[XLEN-1]) |-> irq_en_o); // R5
    AST_RET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pc_sel_o == PCS_RET) |-> (!flush_dec_o && !flush_ex_o && !epc_we_o && !cause_we_o
                                   && pc_target_o == epc_rd_i)); // R7
    AST_RET_ENABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pc_sel_o == PCS_RET) |=> irq_en_o); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ex_fault_i && !dec_illegal_i && !irq_req_i && !trap_ret_i) |->
        (pc_sel_o == PCS_SEQ && !flush_dec_o && !flush_ex_o && !epc_we_o)); // R10

endmodule

// File: tb/sim_trap_ctrl.sv
`timescale 1ns/1ps
module sim_trap_ctrl;

    localparam logic [63:0] BASE = 64'h0000_0000_8000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exf = 1'b0, ill = 1'b0, irq = 1'b0, ret = 1'b0, vm = 1'b0;
    logic [63:0] ex_pc = '0, dec_pc = '0, epc_rd = '0;
    logic        fl_d, fl_e, epc_we, cause_we, en;
    logic [1:0]  sel;
    logic [63:0] tgt, epc_wd, cause_wd;

    int checks = 0;
    int fails  = 0;

    logic        m_en  = 1'b1;
    logic [63:0] m_epc = '0;

    always #2 clk = ~clk;

    trap_ctrl u0 (
        .clk_i(clk), .rst_ni(rst_n),
        .ex_fault_i(exf), .ex_pc_i(ex_pc),
        .dec_illegal_i(ill), .dec_pc_i(dec_pc),
        .irq_req_i(irq), .trap_ret_i(ret), .vec_mode_i(vm), .epc_rd_i(epc_rd),
        .flush_dec_o(fl_d), .flush_ex_o(fl_e), .pc_sel_o(sel), .pc_target_o(tgt),
        .epc_we_o(epc_we), .epc_wdata_o(epc_wd), .cause_we_o(cause_we),
        .cause_wdata_o(cause_wd), .irq_en_o(en)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock cycle: drive, compare against the model, advance the model.
    task automatic step(input logic f, input logic i, input logic q, input logic r, input logic v,
                        input logic [63:0] xpc, input logic [63:0] dpc);
        logic        take, isq;
        logic [5:0]  code;
        logic [63:0] fpc, etgt, ecause;
        logic [1:0]  esel;
        #1;
        exf = f; ill = i; irq = q; ret = r; vm = v; ex_pc = xpc; dec_pc = dpc; epc_rd = m_epc;
        take = 1'b0; isq = 1'b0; code = '0; fpc = '0;
        if (f) begin take = 1'b1; code = 6'd24; fpc = xpc; end          // R4 oldest first
        else if (i) begin take = 1'b1; code = 6'd2; fpc = dpc; end
        else if (q && m_en) begin take = 1'b1; isq = 1'b1; code = 6'd11; fpc = xpc; end // R5
        esel   = take ? 2'd1 : (r ? 2'd2 : 2'd0);
        etgt   = take ? ((v && isq) ? BASE + 64'(code) * 4 : BASE) : m_epc;
        ecause = {isq, 57'd0, code};
        #1;
        chk(en == m_en, "R5 R6 irq_en", {63'd0, en}, {63'd0, m_en});
        chk(sel == esel, "R1 R7 R10 R11 pc_sel", {62'd0, sel}, {62'd0, esel});
        chk(fl_d == take && fl_e == take, "R1 R7 R10 flush", {62'd0, fl_d, fl_e}, {62'd0, take, take});
        chk(epc_we == take && cause_we == take, "R1 R5 write strobes",
            {62'd0, epc_we, cause_we}, {62'd0, take, take});
        if (take) begin
            chk(epc_wd == fpc, "R2 R4 epc data", epc_wd, fpc);
            chk(cause_wd == ecause, "R3 R4 cause data", cause_wd, ecause);
        end
        if (esel != 2'd0) chk(tgt == etgt, "R7 R8 R9 target", tgt, etgt);
        if (take) begin m_en = 1'b0; m_epc = fpc; end                   // R6 R11
        else if (r) m_en = 1'b1;                                        // R7
        @(posedge clk);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(en == 1'b1, "R5 reset enable", {63'd0, en}, 64'd1);
        chk(sel == 2'd0 && !fl_d && !fl_e && !epc_we, "R10 reset idle", {62'd0, sel}, 64'd0);
        @(posedge clk);
        step(0, 0, 0, 0, 0, 64'h100, 64'h104);                   // R10 idle
        step(0, 1, 0, 0, 0, 64'h200, 64'h204);                   // R2 R3 illegal, direct
        step(0, 0, 1, 0, 1, 64'h300, 64'h304);                   // R5 masked interrupt
        step(0, 0, 0, 1, 0, 64'h300, 64'h304);                   // R7 return
        step(0, 0, 1, 0, 1, 64'h400, 64'h404);                   // R9 vectored interrupt
        step(0, 0, 0, 1, 1, 64'h500, 64'h504);                   // R7
        step(0, 0, 1, 0, 0, 64'h600, 64'h604);                   // R8 direct interrupt
        step(0, 0, 0, 1, 0, 64'h600, 64'h604);
        step(1, 1, 1, 0, 1, 64'h700, 64'h704);                   // R4 all sources, fault wins
        step(0, 0, 0, 1, 0, 64'h700, 64'h704);
        step(0, 1, 1, 0, 1, 64'h800, 64'h804);                   // R4 R9 illegal beats irq
        step(1, 0, 0, 1, 0, 64'h900, 64'h904);                   // R11 trap with return
        step(0, 0, 1, 0, 0, 64'hA00, 64'hA04);                   // R6 still masked
        step(0, 0, 0, 1, 0, 64'hA00, 64'hA04);
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] rb;
            rb = 8'($urandom);
            step(rb[2:0] == 3'd0, rb[5:3] == 3'd1, rb[6], rb[7] & rb[0],
                 1'($urandom), {32'd0, $urandom} & ~64'd3, {32'd0, $urandom} & ~64'd3);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule